// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A 32-pin general-purpose I/O bank behind a small memory-mapped write/read port. Software controls the output value and output enable of every pin, reads back the synchronized pin levels, and arms individual pins as interrupt sources. Each armed pin watches for one of four conditions: rising edge, falling edge, high level or low level. A matching condition latches a sticky per-pin status bit. Any latched bit whose enable is also set raises the single bank interrupt line.

Every writable register has three write forms: a plain write, a set form that ORs the data in, and a clear form that removes the bits written as 1. Single pins can therefore change without a read-modify-write. The bus uses a word address. Bits [5:2] select the register and bits [1:0] select the write form. Reads return the selected register no matter what bits [1:0] hold.

Top module: `gpio_irq_bank`

## Requirements
- R1: Register index = addr[5:2]: 0 output data, 1 input data (read-only), 2 output enable, 3 interrupt select, 4 interrupt enable, 5 level/edge (1 = level), 6 polarity (1 = high/rising), 7 status. Write form = addr[1:0]: 0 replaces the value, 1 ORs the data in, 2 clears each bit where the data is 1, 3 does nothing. An index above 7 reads 0.
- R2: pin_o follows the output data register and pin_oe_o follows the output enable register, both in the cycle after the write. An output value written before its enable bit is set is already on pin_o when pin_oe_o goes to 1.
- R3: The input data register returns pin_i through a two-flop synchronizer. A change on pin_i is visible on a read after the second rising clock edge.
- R4: In edge mode (level bit 0), a rising edge of the synchronized pin sets status when polarity is 1, and a falling edge sets it when polarity is 0. The status bit reads 1 one cycle after the edge reaches the input data register.
- R5: In level mode (level bit 1), status is set on every cycle the pin is at the active level: high for polarity 1, low for polarity 0. A clear takes effect only after the pin has left that level.
- R6: A pin sets status only while both its interrupt select bit and its interrupt enable bit are 1.
- R7: Status bits change from 1 to 0 only through the clear form (addr[1:0] = 2). Plain and set writes to status have no effect. Writing all ones through the clear form clears every pending bit.
- R8: If a hardware event and a clear-form write hit the same status bit in the same cycle, the bit ends up set.
- R9: irq_o is 1 exactly when (status AND interrupt enable) is nonzero. Clearing an enable bit masks that pin's pending status from irq_o but leaves the status bit set.
- R10: After reset every register, including status, reads 0, and irq_o, pin_o and pin_oe_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 6 | Word address: [5:2] register, [1:0] write form |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| pin_i | input | 32 | Pad input levels |
| pin_o | output | 32 | Pad output values |
| pin_oe_o | output | 32 | Pad output enables |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
All four detection modes are driven on single pins. Rising and falling edges are tested on one pin, with the polarity flipped while the pin is held still, which shows that a mode change alone raises nothing. A low-level pin is held active while software clears its status, which separates level latching from edge latching. A pin that is enabled but not selected shows that both gates are needed. A clear placed in the same cycle as an edge event shows whether the hardware set takes priority. A behavioural model compares the pins, irq_o and the read data on every cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned NREG  = 8;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [1:0] {
    ALS_WR   = 2'd0,
    ALS_SET  = 2'd1,
    ALS_CLR  = 2'd2,
    ALS_NONE = 2'd3
  } alias_e;

  localparam logic [IDX_W-1:0] RI_DOUT = 4'd0;
  localparam logic [IDX_W-1:0] RI_DIN  = 4'd1;
  localparam logic [IDX_W-1:0] RI_DOE  = 4'd2;
  localparam logic [IDX_W-1:0] RI_SEL  = 4'd3;
  localparam logic [IDX_W-1:0] RI_IEN  = 4'd4;
  localparam logic [IDX_W-1:0] RI_LVL  = 4'd5;
  localparam logic [IDX_W-1:0] RI_POL  = 4'd6;
  localparam logic [IDX_W-1:0] RI_STAT = 4'd7;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (wr_i)  q_o <= data_i;
    else if (set_i) q_o <= q_o | data_i;
    else if (clr_i) q_o <= q_o & ~data_i;
  end

  AST_SET_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(set_i) && !$past(wr_i) |-> (($past(data_i) & ~q_o) == '0)); // R1
  AST_CLR_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) && !$past(wr_i) && !$past(set_i) |-> ((q_o & $past(data_i)) == '0)); // R1
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall, lvl_act, edge_act;

  assign rise     = din_i & ~prev_q;
  assign fall     = ~din_i & prev_q;
  assign lvl_act  = ~(din_i ^ pol_i);
  assign edge_act = (pol_i & rise) | (~pol_i & fall);
  assign hit_o    = src_i & ((lvl_i & lvl_act) | (~lvl_i & edge_act));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_o <= '0;
    end else begin
      prev_q <= din_i;
      stat_o <= (stat_o & ~clr_i) | hit_o; // hardware set wins
    end
  end

  AST_STAT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_o & ~$past(stat_o) & ~$past(src_i)) == '0)); // R6
  AST_STAT_CLR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(stat_o) & ~stat_o & ~$past(clr_i)) == '0)); // R7
  AST_HW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(hit_o) & ~stat_o) == '0)); // R8
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPIN-1:0]   bus_wdata_i,
  output logic [NPIN-1:0]   bus_rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic              irq_o
);
  logic [IDX_W-1:0] idx;
  alias_e           als;
  logic [NPIN-1:0]  regs [NREG];
  logic [NPIN-1:0]  din, src, stat_clr, stat, hit;

  assign idx = bus_addr_i[ADDR_W-1:2];
  assign als = alias_e'(bus_addr_i[1:0]);

  for (genvar g = 0; g < int'(NREG); g++) begin : g_reg
    if (g != int'(RI_DIN) && g != int'(RI_STAT)) begin : g_rw
      logic hit_idx;
      assign hit_idx = bus_we_i && (idx == IDX_W'(g));
      gpio_setclr_reg #(.W(NPIN)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (hit_idx && als == ALS_WR),
        .set_i  (hit_idx && als == ALS_SET),
        .clr_i  (hit_idx && als == ALS_CLR),
        .data_i (bus_wdata_i),
        .q_o    (regs[g])
      );
    end
  end

  gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (din)
  );

  assign regs[RI_DIN]  = din;
  assign regs[RI_STAT] = stat;
  assign src      = regs[RI_IEN] & regs[RI_SEL];
  assign stat_clr = (bus_we_i && idx == RI_STAT && als == ALS_CLR) ? bus_wdata_i : '0;

  gpio_irq_detect #(.W(NPIN)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (din),
    .src_i  (src),
    .lvl_i  (regs[RI_LVL]),
    .pol_i  (regs[RI_POL]),
    .clr_i  (stat_clr),
    .stat_o (stat),
    .hit_o  (hit)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < int'(NREG); i++)
      if (idx == IDX_W'(i)) bus_rdata_o = regs[i];
  end

  assign pin_o    = regs[RI_DOUT];
  assign pin_oe_o = regs[RI_DOE];
  assign irq_o    = |(stat & regs[RI_IEN]);

  AST_OE_SET_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_we_i && idx == RI_DOE && als == ALS_SET) |->
    ((pin_oe_o & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R2
endmodule

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        we = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic [31:0] pin_o, pin_oe_o;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  gpio_irq_bank dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq)
  );

  // behavioural reference model
  logic [31:0] m_reg [8];
  logic [31:0] m_s1, m_s2, m_prev, m_stat;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++) m_reg[i] = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_stat = 0;
    end else begin
      logic [31:0] hitv, clrv;
      int ri;
      hitv = 0;
      for (int p = 0; p < 32; p++) begin
        bit act;
        case ({m_reg[5][p], m_reg[6][p]})
          2'b00: act = !m_s2[p] && m_prev[p];
          2'b01: act = m_s2[p] && !m_prev[p];
          2'b10: act = !m_s2[p];
          default: act = m_s2[p];
        endcase
        if (act && m_reg[4][p] && m_reg[3][p]) hitv[p] = 1;
      end
      ri = int'(addr[5:2]);
      clrv = (we && ri == 7 && addr[1:0] == 2) ? wdata : 0;
      m_stat = (m_stat & ~clrv) | hitv;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
      if (we && ri < 8 && ri != 1 && ri != 7) begin
        case (addr[1:0])
          2'd0: m_reg[ri] = wdata;
          2'd1: m_reg[ri] = m_reg[ri] | wdata;
          2'd2: m_reg[ri] = m_reg[ri] & ~wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare
  always @(negedge clk) if (rst_ni && !done) begin
    logic [31:0] exp_rd;
    int ri;
    ri = int'(addr[5:2]);
    exp_rd = (ri == 1) ? m_s2 : (ri == 7) ? m_stat : (ri < 8) ? m_reg[ri] : 0;
    chk("R2 pin_o", pin_o, m_reg[0]);
    chk("R2 pin_oe_o", pin_oe_o, m_reg[2]);
    chk("R9 irq_o", {31'd0, irq}, {31'd0, |(m_stat & m_reg[4])});
    chk("R1 rdata", rdata, exp_rd);
  end

  task automatic wr(int ri, int als, logic [31:0] d);
    @(posedge clk); #2;
    we = 1; addr = {4'(ri), 2'(als)}; wdata = d;
    @(posedge clk); #2;
    we = 0;
  endtask

  task automatic rd(int ri, output logic [31:0] d);
    @(posedge clk); #2;
    addr = {4'(ri), 2'b00};
    @(negedge clk);
    d = rdata;
  endtask

  task automatic setpin(int p, bit v);
    @(posedge clk); #2;
    pins[p] = v;
  endtask

  task automatic waitc(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #2 rst_ni = 1;

    // R10 reset state
    for (int i = 0; i < 8; i++) begin
      rd(i, d); chk("R10 reset reg", d, 0);
    end
    chk("R10 irq", {31'd0, irq}, 0);
    rd(9, d); chk("R1 unused index", d, 0);

    // R1 write forms
    wr(0, 0, 32'h0F0F_0000);
    wr(0, 1, 32'h0000_00FF);
    wr(0, 2, 32'h0F00_0001);
    wr(0, 3, 32'hFFFF_FFFF);
    rd(0, d); chk("R1 dout forms", d, 32'h000F_00FE);

    // R2 value before enable
    wr(0, 1, 32'h0000_0020);
    wr(2, 1, 32'h0000_0020);
    @(negedge clk);
    chk("R2 oe bit5", {31'd0, pin_oe_o[5]}, 1);
    chk("R2 out bit5", {31'd0, pin_o[5]}, 1);

    // R3 two-flop delay
    rd(1, d);
    @(posedge clk); #2 pins = 32'hA5A5_0000;
    @(negedge clk); chk("R3 din before", rdata, 0);
    @(negedge clk); chk("R3 din mid", rdata, 0);
    @(negedge clk); chk("R3 din after", rdata, 32'hA5A5_0000);

    // R4 rising then falling edge on pin 3
    wr(3, 1, 32'h8); wr(4, 1, 32'h8); wr(5, 2, 32'h8); wr(6, 1, 32'h8);
    rd(7, d); chk("R4 no event yet", d, 0);
    setpin(3, 1); waitc(3);
    rd(7, d); chk("R4 rising", d, 32'h8);
    chk("R9 irq set", {31'd0, irq}, 1);
    wr(7, 2, 32'h8);
    rd(7, d); chk("R7 clear", d, 0);
    wr(6, 2, 32'h8); waitc(3);
    rd(7, d); chk("R4 pol change no event", d, 0);
    setpin(3, 0); waitc(3);
    rd(7, d); chk("R4 falling", d, 32'h8);
    wr(7, 2, 32'h8);

    // R6 enabled but not selected
    wr(6, 1, 32'h200); wr(4, 1, 32'h200);
    setpin(9, 1); waitc(4);
    rd(7, d); chk("R6 unselected", d, 0);

    // R5 level low on pin 12
    wr(3, 1, 32'h1000); wr(4, 1, 32'h1000); wr(5, 1, 32'h1000);
    waitc(2);
    rd(7, d); chk("R5 level active", d, 32'h1000);
    wr(7, 2, 32'h1000);
    rd(7, d); chk("R5 clear while active", d, 32'h1000);
    setpin(12, 1); waitc(3);
    wr(7, 2, 32'h1000);
    rd(7, d); chk("R5 clear after leave", d, 0);

    // R7 plain and set writes ignored
    setpin(3, 1); waitc(3);
    setpin(3, 0); waitc(3);
    rd(7, d); chk("R7 pending", d, 32'h8);
    wr(7, 0, 32'h0);
    rd(7, d); chk("R7 plain ignored", d, 32'h8);
    wr(7, 1, 32'hFFFF_0000);
    rd(7, d); chk("R7 set ignored", d, 32'h8);
    wr(7, 2, 32'hFFFF_FFFF);
    rd(7, d); chk("R7 clear all", d, 0);

    // R8 clear in the event cycle
    setpin(3, 1); waitc(3);
    @(posedge clk); #2 pins[3] = 0;
    @(posedge clk);
    @(posedge clk); #2;
    we = 1; addr = {4'd7, 2'd2}; wdata = 32'h8;
    @(posedge clk); #2 we = 0;
    rd(7, d); chk("R8 hw set wins", d, 32'h8);

    // R9 masking by enable
    wr(4, 2, 32'h8);
    rd(7, d); chk("R9 status kept", d, 32'h8);
    chk("R9 irq masked", {31'd0, irq}, 0);
    wr(4, 1, 32'h8);
    @(negedge clk); chk("R9 irq unmasked", {31'd0, irq}, 1);

    waitc(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule